// File: doc/BRIEF.md
# Complementary PWM Timer with Deadband

This block is a 16-bit up-counting PWM timer. It drives a pair of complementary outputs and inserts a programmable dead time before either output switches on. The counter advances on ticks from a power-of-two prescaler, which runs from the system clock. When the count equals the match value, the primary output switches to its active level. When the count equals the reload value, the block raises a one-cycle interrupt, the output returns to its idle level and the count restarts at one. A starting count written by software sets the length of the first period only.

The second output carries the inverse of the primary PWM level. Each output then passes through a deadband stage that delays its low-to-high edge by a programmed number of system clocks and lets its high-to-low edge through at once. As a result the two pins are never high together. Software programs the block through a write-only register port. It clears the enable bit before it changes the configuration.

Top module: `pwm_pair_timer`

## Requirements
- R1: While enabled, the counter advances once every 2^S system clocks, where S is control bits [4:2]. The prescaler restarts from zero whenever the timer is enabled, so the first advance lands 2^S clocks after the enable write takes effect.
- R2: On an advance where the count equals the match value (register address 2), the PWM level switches to its active state: high when polarity is 0, low when polarity is 1.
- R3: On an advance where the count equals the reload value (address 3), the count becomes 1, the PWM level returns to its idle state, and `reload_irq` is high for exactly one system clock. With prescale 1 and a starting count of 1, pulses therefore come every `reload` clocks.
- R4: Control bit 1 selects polarity. When it is 1, the primary level idles high and is active low. When it is 0, the levels are the reverse.
- R5: The secondary output follows the inverse of the primary PWM level, passed through its own deadband stage.
- R6: Each output rises D+1 system clocks after its underlying level rises and falls one clock after that level falls, where D is the deadband register (address 4, 0 to 128). The two outputs are never high in the same cycle.
- R7: If an output's underlying level falls before its deadband delay has expired, the pending rise is dropped and that output stays low.
- R8: Writing address 1 loads the count directly and returns the PWM level to idle. That value sets the length of the first period only, and every later period starts at 1.
- R9: While control bit 0 (enable) is 0, both outputs are low and the count and PWM level hold their values.
- R10: After reset, both outputs and `reload_irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 start count, 2 match, 3 reload, 4 deadband |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Primary PWM output with deadband |
| pwm_out_n | output | 1 | Complementary PWM output with deadband |
| reload_irq | output | 1 | One-clock pulse on each reload |

## Verification
The case that is hardest to reach from the ports is a deadband that outlasts one PWM phase. The pending rise must then be cancelled, and neither output may ever overlap the other. Software would never program such a setting deliberately. The stimulus therefore sets up a directed short active phase with a long delay. Random configurations then draw deadbands that sometimes exceed a phase, and they disable and re-enable the timer in mid-period. Every cycle is compared against a bench model built from the requirements.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  // register addresses
  localparam int ADR_CTRL   = 0;
  localparam int ADR_START  = 1;
  localparam int ADR_MATCH  = 2;
  localparam int ADR_RELOAD = 3;
  localparam int ADR_DBAND  = 4;
  // control field positions
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_POL_BIT = 1;
  localparam int CTL_PS_LSB  = 2;
  // number of outputs in the pair
  localparam int N_OUT = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sel));
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
    else pre_q <= '0;
  end

  // R1
  pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (pre_q == '0));
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             ld_start,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic             phase,
  output logic             irq
);
  localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             hit_reload, hit_match;

  assign hit_reload = (cnt_q == reload_val);
  assign hit_match  = (cnt_q == match_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RESTART;
      phase <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= tick && hit_reload;
      if (ld_start) begin
        cnt_q <= start_val;
        phase <= 1'b0;
      end else if (tick) begin
        if (hit_reload) begin
          cnt_q <= RESTART;
          phase <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (hit_match) phase <= 1'b1;
        end
      end
    end
  end

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (cnt_q == RESTART || $past(ld_start)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_start) |=> (cnt_q == $past(cnt_q) && phase == $past(phase)));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  input  logic [DB_W-1:0] delay,
  output logic            dout
);
  logic [DB_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= 1'b0;
      wait_q <= '0;
    end else if (!din) begin
      dout   <= 1'b0;
      wait_q <= '0;
    end else if (wait_q >= delay) begin
      dout <= 1'b1;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end

  // R6
  fall_now_chk: assert property (@(posedge clk) disable iff (rst)
    !din |=> !dout);
  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dout) |-> $past(din));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int DB_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic              pwm_out_n,
  output logic              reload_irq
);
  logic             en_q, pol_q;
  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] match_q, reload_q;
  logic [DB_W-1:0]  db_q;
  logic             ld_start, tick, phase, irq;
  logic             level;
  logic [N_OUT-1:0] drive, outs;

  assign ld_start = wr_en && (wr_addr == ADDR_W'(ADR_START));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      pol_q    <= 1'b0;
      ps_q     <= '0;
      match_q  <= '0;
      reload_q <= '1;
      db_q     <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADR_CTRL)) begin
        en_q  <= wr_data[CTL_EN_BIT];
        pol_q <= wr_data[CTL_POL_BIT];
        ps_q  <= wr_data[CTL_PS_LSB +: PS_W];
      end
      if (wr_addr == ADDR_W'(ADR_MATCH))  match_q  <= wr_data;
      if (wr_addr == ADDR_W'(ADR_RELOAD)) reload_q <= wr_data;
      if (wr_addr == ADDR_W'(ADR_DBAND))  db_q     <= wr_data[DB_W-1:0];
    end
  end

  pwm_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .run(en_q), .sel(ps_q), .tick(tick)
  );

  pwm_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(en_q), .tick(tick), .ld_start(ld_start),
    .start_val(wr_data), .match_val(match_q), .reload_val(reload_q),
    .phase(phase), .irq(irq)
  );

  assign level    = pol_q ^ phase;
  assign drive[0] = en_q & level;
  assign drive[1] = en_q & ~level;

  for (genvar g = 0; g < N_OUT; g++) begin : g_band
    pwm_deadband #(.DB_W(DB_W)) u_db (
      .clk(clk), .rst(rst), .din(drive[g]), .delay(db_q), .dout(outs[g])
    );
  end

  assign pwm_out    = outs[0];
  assign pwm_out_n  = outs[1];
  assign reload_irq = irq;

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(pwm_out && pwm_out_n));
  // R9
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !(pwm_out || pwm_out_n));
endmodule

// File: tb/pwm_pair_timer_test.sv
module pwm_pair_timer_test;
  localparam int CYC = 20;

  logic        clk = 0, rst = 1, wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic        pwm_out, pwm_out_n, reload_irq;

  int total = 0, fails = 0;
  bit cmp_on = 0;

  always #(CYC/2) clk = ~clk;

  pwm_pair_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_out_n(pwm_out_n), .reload_irq(reload_irq)
  );

  // reference model built from the requirements
  logic        m_en, m_pol, m_phase, m_irq;
  logic [2:0]  m_ps;
  logic [15:0] m_cnt, m_match, m_reload;
  logic [7:0]  m_db, m_wait[2];
  logic [6:0]  m_pre;
  logic        m_q[2];

  function automatic logic [6:0] ps_mask(input logic [2:0] s);
    return 7'((8'd1 << s) - 8'd1);
  endfunction

  always @(posedge clk) begin
    logic t, lvl;
    logic d[2];
    if (rst) begin
      m_en <= 0; m_pol <= 0; m_ps <= 0; m_match <= 0; m_reload <= 16'hFFFF;
      m_db <= 0; m_cnt <= 1; m_phase <= 0; m_irq <= 0; m_pre <= 0;
      for (int i = 0; i < 2; i++) begin m_wait[i] <= 0; m_q[i] <= 0; end
    end else begin
      t = m_en && ((m_pre & ps_mask(m_ps)) == ps_mask(m_ps));
      m_pre <= m_en ? m_pre + 1 : 0;
      m_irq <= t && (m_cnt == m_reload);
      if (wr_en && wr_addr == 1) begin m_cnt <= wr_data; m_phase <= 0; end
      else if (t) begin
        if (m_cnt == m_reload) begin m_cnt <= 1; m_phase <= 0; end
        else begin m_cnt <= m_cnt + 1; if (m_cnt == m_match) m_phase <= 1; end
      end
      lvl = m_pol ^ m_phase;
      d[0] = m_en & lvl;
      d[1] = m_en & ~lvl;
      for (int i = 0; i < 2; i++) begin
        if (!d[i]) begin m_q[i] <= 0; m_wait[i] <= 0; end
        else if (m_wait[i] >= m_db) m_q[i] <= 1;
        else m_wait[i] <= m_wait[i] + 1;
      end
      if (wr_en) case (wr_addr)
        0: begin m_en <= wr_data[0]; m_pol <= wr_data[1]; m_ps <= wr_data[4:2]; end
        2: m_match <= wr_data;
        3: m_reload <= wr_data;
        4: m_db <= wr_data[7:0];
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(pwm_out == m_q[0], "R2", "pwm_out vs model", pwm_out, m_q[0]);
    chk(pwm_out_n == m_q[1], "R5", "pwm_out_n vs model", pwm_out_n, m_q[1]);
    chk(reload_irq == m_irq, "R3", "reload_irq vs model", reload_irq, m_irq);
    chk(!(pwm_out && pwm_out_n), "R6", "overlap", 1, 0);
  end

  task automatic wr(input int a, input int d);
    wr_addr = 3'(a); wr_data = 16'(d); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic setup(input int ps, input int pol, input int st, input int mt,
                       input int rl, input int db);
    wr(0, 0);
    wr(1, st); wr(2, mt); wr(3, rl); wr(4, db);
    wr(0, 1 | (pol << 1) | (ps << 2));
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!reload_irq && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(CYC * 150000);
    chk(0, "ALL", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, seen_p, seen_n;
    void'($urandom(32'd7421));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!pwm_out && !pwm_out_n && !reload_irq, "R10", "reset outputs",
        {pwm_out, pwm_out_n, reload_irq}, 0);
    cmp_on = 1;

    // R8 first period from start count, R3 later periods from 1
    setup(0, 0, 8, 5, 10, 0);
    wait_irq(n);
    chk(n == 3, "R8", "clocks to first irq", n, 3);
    @(negedge clk);
    chk(!reload_irq, "R3", "irq width", reload_irq, 0);
    wait_irq(n);
    chk(n == 9, "R3", "clocks between irqs", n + 1, 10);

    // R9 disable drives outputs low
    repeat (4) @(negedge clk);
    wr(0, 0);
    @(negedge clk);
    chk(!pwm_out && !pwm_out_n, "R9", "outputs while off", {pwm_out, pwm_out_n}, 0);
    repeat (20) @(negedge clk);
    chk(!reload_irq, "R9", "no irq while off", reload_irq, 0);

    // R4 polarity 1: primary starts high
    setup(0, 1, 1, 30, 40, 0);
    @(negedge clk);
    chk(pwm_out == 1 && pwm_out_n == 0, "R4", "inverted idle level",
        {pwm_out, pwm_out_n}, 2);

    // R1 prescale 4: first advance 4 clocks after enable
    setup(2, 0, 9, 3, 10, 0);
    wait_irq(n);
    chk(n == 8, "R1", "clocks to irq with prescale 4", n, 8);

    // R6 deadband delay of 5 on the primary rise
    setup(0, 0, 1, 10, 40, 5);
    n = 0;
    while (!pwm_out && n < 200) begin @(negedge clk); n++; end
    chk(n == 16, "R6", "primary rise clocks after enable", n, 16);

    // R7 deadband longer than active phase: primary never rises
    setup(0, 0, 1, 17, 20, 10);
    seen_p = 0; seen_n = 0;
    repeat (100) begin
      @(negedge clk);
      seen_p |= pwm_out; seen_n |= pwm_out_n;
    end
    chk(seen_p == 0, "R7", "cancelled primary rise", seen_p, 0);
    chk(seen_n == 1, "R7", "complement still rises", seen_n, 1);

    // random configurations compared against the model
    for (int k = 0; k < 14; k++) begin
      int rl, mt, st, ps, db;
      ps = $urandom % 3;
      rl = 8 + $urandom % 40;
      mt = 1 + $urandom % (rl - 2);
      st = 1 + $urandom % rl;
      db = $urandom % 20;
      setup(ps, $urandom % 2, st, mt, rl, db);
      repeat (200 + $urandom % 300) @(negedge clk);
      if ($urandom % 2) begin
        wr(0, 0);
        repeat (5 + $urandom % 20) @(negedge clk);
        wr(0, 1 | ((k & 1) << 1) | (ps << 2));
        repeat (200) @(negedge clk);
      end
    end

    cmp_on = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule